// File: doc/BRIEF.md
# Descriptor Ring Pointer Unit

This block holds the register state for one circular queue of 32-byte DMA descriptors. Software programs a base address, a ring size and two level thresholds through a simple word-addressed register port. The unit keeps a producer pointer and a consumer pointer. It reports how many descriptors sit between them, and it raises empty, full, almost-empty and almost-full levels that the engine and the interrupt logic can use.

One pointer belongs to software and the other belongs to the engine. With the default `SW_PRODUCER = 1`, software writes the producer pointer and the engine moves the consumer pointer one descriptor at a time through `eng_adv`. With `SW_PRODUCER = 0` the roles are swapped. A separate gate register locks the configuration fields. The base, the ring size and the engine-owned pointer accept writes only while their gate bit is set. This keeps a stray store from disturbing a running ring. Pointers read back as byte offsets, and a pointer's descriptor index is that value shifted right by 5. The ring size is written as the descriptor count shifted left by 3. Writes whose two low address bits are non-zero are dropped.

Top module: `ring_ptr_unit`

## Requirements
- R1: After reset both pointers and the base read 0, the gate reads 0, the size register reads 8192 (1024 descriptors shifted left by 3), the count is 0, `q_empty` and `q_aempty` are 1, and `q_full` and `q_afull` are 0.
- R2: A write to the base register (offset 0x00) takes effect only while gate bit 2 is 1. The gate register is at offset 0x1C.
- R3: A write to the size register (offset 0x04) takes effect only while gate bit 1 is 1. The written value must also have bits [2:0] clear and encode a power-of-two count from 2 to 1024. Any other value leaves the size unchanged.
- R4: The engine-owned pointer (the read pointer at offset 0x0C by default) accepts a register write only while gate bit 0 is 1. The software-owned pointer (the write pointer at offset 0x08) always accepts writes.
- R5: A pointer write keeps bits [14:5] of the data, masked by the ring size minus one. A pointer reads back as its index shifted left by 5, so bits [4:0] read 0.
- R6: The count equals (write index − read index) modulo the ring size. It appears on `q_count` and at offset 0x10.
- R7: `q_empty` is 1 exactly when the count is 0. `q_full` is 1 exactly when the count equals the ring size minus one.
- R8: `q_aempty` is 1 when the count is at or below the threshold at offset 0x14. `q_afull` is 1 when the count is at or above the threshold at offset 0x18.
- R9: Each cycle with `eng_adv` high moves the engine-owned pointer on by 32 bytes, wrapping at the ring size. The move is ignored while the ring is empty (or full when `SW_PRODUCER = 0`).
- R10: When a gated register write to the engine-owned pointer and `eng_adv` occur in the same cycle, the written value wins.
- R11: `eng_desc_addr` equals the base plus the byte offset of the engine-owned pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| eng_adv | input | 1 | Engine request to advance its pointer by one descriptor |
| eng_ptr | output | 15 | Byte offset of the engine-owned pointer |
| eng_desc_addr | output | 32 | Base plus engine pointer offset |
| q_count | output | 10 | Descriptors between the pointers |
| q_empty | output | 1 | Count is zero |
| q_full | output | 1 | Count is ring size minus one |
| q_aempty | output | 1 | Count at or below the almost-empty threshold |
| q_afull | output | 1 | Count at or above the almost-full threshold |

## Verification
The hardest state to reach is a ring where the pointers sit at every possible pair of positions, including pairs that straddle the wrap point, under several ring sizes. The engine port alone would need hundreds of advance pulses to get there. The bench opens the gate so that it can load the engine-owned pointer directly. It then sweeps every pair of write and read indices for ring sizes 2, 4, 8 and 16. Each software pointer write carries an index beyond the ring size plus junk in the low bits, so masking is checked on every write. The bench also drives a gated load in the same cycle as an advance pulse to check which one wins.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;
    localparam int REG_AW      = 5;
    localparam int DESC_SHIFT  = 5;
    localparam int DEPTH_SHIFT = 3;

    localparam int GATE_W      = 3;
    localparam int GATE_BASE   = 2;
    localparam int GATE_DEPTH  = 1;
    localparam int GATE_ENGPTR = 0;

    // register select is the word index of the byte address
    typedef enum logic [2:0] {
        SEL_BASE  = 3'd0,
        SEL_DEPTH = 3'd1,
        SEL_WPTR  = 3'd2,
        SEL_RPTR  = 3'd3,
        SEL_COUNT = 3'd4,
        SEL_AE    = 3'd5,
        SEL_AF    = 3'd6,
        SEL_GATE  = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs
    import ring_ptr_pkg::*;
#(
    parameter int DW    = 32,
    parameter int IDX_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     base_q,
    output logic [IDX_W:0]    depth_cnt_q,
    output logic [IDX_W-1:0]  mask,
    output logic [IDX_W-1:0]  ae_th_q,
    output logic [IDX_W-1:0]  af_th_q,
    output logic [GATE_W-1:0] gate_q
);
    localparam int CNT_W = IDX_W + 1;
    localparam int TOP_L = DEPTH_SHIFT + CNT_W;

    logic [CNT_W-1:0] wr_cnt;
    logic             depth_ok;

    assign wr_cnt   = wdata[DEPTH_SHIFT +: CNT_W];
    assign depth_ok = (wdata[DEPTH_SHIFT-1:0] == '0) &&
                      (wdata[DW-1:TOP_L] == '0) &&
                      ($countones(wr_cnt) == 1) && !wr_cnt[0];

    // mask bit i is set when the count has a one above position i
    for (genvar i = 0; i < IDX_W; i++) begin : g_mask
        assign mask[i] = ((depth_cnt_q >> (i + 1)) != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q      <= '0;
            depth_cnt_q <= CNT_W'(1) << IDX_W;
            ae_th_q     <= '0;
            af_th_q     <= '1;
            gate_q      <= '0;
        end else if (wr) begin
            unique case (sel)
                SEL_BASE:  if (gate_q[GATE_BASE]) base_q <= wdata;
                SEL_DEPTH: if (gate_q[GATE_DEPTH] && depth_ok) depth_cnt_q <= wr_cnt;
                SEL_AE:    ae_th_q <= wdata[IDX_W-1:0];
                SEL_AF:    af_th_q <= wdata[IDX_W-1:0];
                SEL_GATE:  gate_q  <= wdata[GATE_W-1:0];
                SEL_WPTR, SEL_RPTR, SEL_COUNT: ;
            endcase
        end
    end
endmodule

// File: rtl/ring_index.sv
module ring_index #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             adv,
    input  logic [IDX_W-1:0] mask,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    idx_q <= '0;
        else if (load) idx_q <= load_idx & mask;
        else if (adv)  idx_q <= (idx_q + 1'b1) & mask;
    end

    assign idx = idx_q & mask;
endmodule

// File: rtl/ring_level.sv
module ring_level #(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] mask,
    input  logic [IDX_W-1:0] ae_th,
    input  logic [IDX_W-1:0] af_th,
    output logic [IDX_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             aempty,
    output logic             afull
);
    always_comb begin
        count  = (wr_idx - rd_idx) & mask;
        empty  = (count == '0);
        full   = (count == mask);
        aempty = (count <= ae_th);
        afull  = (count >= af_th);
    end
endmodule

// File: rtl/ring_ptr_unit.sv
module ring_ptr_unit
    import ring_ptr_pkg::*;
#(
    parameter int DW          = 32,
    parameter int IDX_W       = 10,
    parameter bit SW_PRODUCER = 1'b1,
    localparam int PTR_W      = IDX_W + DESC_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              eng_adv,
    output logic [PTR_W-1:0]  eng_ptr,
    output logic [DW-1:0]     eng_desc_addr,
    output logic [IDX_W-1:0]  q_count,
    output logic              q_empty,
    output logic              q_full,
    output logic              q_aempty,
    output logic              q_afull
);
    reg_sel_e          sel;
    logic              wr_ok;
    logic [DW-1:0]     base_q;
    logic [IDX_W:0]    depth_cnt_q;
    logic [IDX_W-1:0]  mask;
    logic [IDX_W-1:0]  ae_th_q, af_th_q;
    logic [GATE_W-1:0] gate_q;
    logic [IDX_W-1:0]  w_idx, r_idx, eng_idx, load_idx;
    logic              w_load, r_load, w_adv, r_adv;

    assign sel      = reg_sel_e'(reg_addr[REG_AW-1:2]);
    assign wr_ok    = reg_wr && (reg_addr[1:0] == 2'b00);
    assign load_idx = reg_wdata[DESC_SHIFT +: IDX_W];

    ring_cfg_regs #(.DW(DW), .IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(wr_ok), .sel(sel), .wdata(reg_wdata),
        .base_q(base_q), .depth_cnt_q(depth_cnt_q), .mask(mask),
        .ae_th_q(ae_th_q), .af_th_q(af_th_q), .gate_q(gate_q)
    );

    // ownership variant: which pointer the engine moves and which one is gated
    if (SW_PRODUCER) begin : g_sw_prod
        assign w_load  = wr_ok && (sel == SEL_WPTR);
        assign w_adv   = 1'b0;
        assign r_load  = wr_ok && (sel == SEL_RPTR) && gate_q[GATE_ENGPTR];
        assign r_adv   = eng_adv && !q_empty;
        assign eng_idx = r_idx;
    end else begin : g_eng_prod
        assign w_load  = wr_ok && (sel == SEL_WPTR) && gate_q[GATE_ENGPTR];
        assign w_adv   = eng_adv && !q_full;
        assign r_load  = wr_ok && (sel == SEL_RPTR);
        assign r_adv   = 1'b0;
        assign eng_idx = w_idx;
    end

    ring_index #(.IDX_W(IDX_W)) u_widx (
        .clk(clk), .rst_n(rst_n), .load(w_load), .load_idx(load_idx),
        .adv(w_adv), .mask(mask), .idx(w_idx)
    );

    ring_index #(.IDX_W(IDX_W)) u_ridx (
        .clk(clk), .rst_n(rst_n), .load(r_load), .load_idx(load_idx),
        .adv(r_adv), .mask(mask), .idx(r_idx)
    );

    ring_level #(.IDX_W(IDX_W)) u_level (
        .wr_idx(w_idx), .rd_idx(r_idx), .mask(mask),
        .ae_th(ae_th_q), .af_th(af_th_q), .count(q_count),
        .empty(q_empty), .full(q_full), .aempty(q_aempty), .afull(q_afull)
    );

    assign eng_ptr       = {eng_idx, {DESC_SHIFT{1'b0}}};
    assign eng_desc_addr = base_q + DW'(eng_ptr);

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_BASE:  reg_rdata = base_q;
            SEL_DEPTH: reg_rdata = DW'({depth_cnt_q, {DEPTH_SHIFT{1'b0}}});
            SEL_WPTR:  reg_rdata = DW'({w_idx, {DESC_SHIFT{1'b0}}});
            SEL_RPTR:  reg_rdata = DW'({r_idx, {DESC_SHIFT{1'b0}}});
            SEL_COUNT: reg_rdata = DW'(q_count);
            SEL_AE:    reg_rdata = DW'(ae_th_q);
            SEL_AF:    reg_rdata = DW'(af_th_q);
            SEL_GATE:  reg_rdata = DW'(gate_q);
        endcase
    end
endmodule

// File: rtl/ring_ptr_unit_chk.sv
module ring_ptr_unit_chk
    import ring_ptr_pkg::*;
#(
    parameter int DW          = 32,
    parameter int IDX_W       = 10,
    parameter bit SW_PRODUCER = 1'b1,
    localparam int PTR_W      = IDX_W + DESC_SHIFT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [IDX_W-1:0]  wr_idx_data,
    input logic              eng_adv,
    input logic [PTR_W-1:0]  eng_ptr,
    input logic              q_empty,
    input logic              q_full,
    input logic [GATE_W-1:0] gate_q,
    input logic [DW-1:0]     base_q,
    input logic [IDX_W:0]    depth_cnt_q,
    input logic [IDX_W-1:0]  mask
);
    localparam logic [2:0] ENG_SEL = SW_PRODUCER ? 3'(SEL_RPTR) : 3'(SEL_WPTR);

    logic blocked;
    assign blocked = SW_PRODUCER ? q_empty : q_full;

    a_r7_empty_full_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_empty && q_full));

    a_r9_adv_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_adv && !blocked && !reg_wr) |=> (eng_ptr != $past(eng_ptr)));

    a_r9_adv_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_adv && blocked && !reg_wr) |=> $stable(eng_ptr));

    a_r3_depth_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 5'h04 && !gate_q[GATE_DEPTH]) |=> $stable(depth_cnt_q));

    a_r2_base_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 5'h00 && !gate_q[GATE_BASE]) |=> $stable(base_q));

    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr[1:0] == 2'b00 && reg_addr[4:2] == ENG_SEL &&
         gate_q[GATE_ENGPTR] && eng_adv)
        |=> (eng_ptr[PTR_W-1:DESC_SHIFT] == ($past(wr_idx_data) & $past(mask))));
endmodule

bind ring_ptr_unit ring_ptr_unit_chk #(
    .DW(DW), .IDX_W(IDX_W), .SW_PRODUCER(SW_PRODUCER)
) i_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .wr_idx_data(reg_wdata[5 +: IDX_W]), .eng_adv(eng_adv), .eng_ptr(eng_ptr),
    .q_empty(q_empty), .q_full(q_full), .gate_q(gate_q), .base_q(base_q),
    .depth_cnt_q(depth_cnt_q), .mask(mask)
);

// File: tb/test_ring_ptr_unit.sv
module test_ring_ptr_unit;
    localparam logic [4:0] A_BASE = 5'h00, A_DEPTH = 5'h04, A_WPTR = 5'h08,
                           A_RPTR = 5'h0C, A_COUNT = 5'h10, A_AE = 5'h14,
                           A_AF = 5'h18, A_GATE = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_adv = 1'b0;
    logic [14:0] eng_ptr;
    logic [31:0] eng_desc_addr;
    logic [9:0]  q_count;
    logic        q_empty, q_full, q_aempty, q_afull;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ring_ptr_unit i_ring_ptr_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_adv(eng_adv),
        .eng_ptr(eng_ptr), .eng_desc_addr(eng_desc_addr), .q_count(q_count),
        .q_empty(q_empty), .q_full(q_full), .q_aempty(q_aempty), .q_afull(q_afull)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        chk(v == exp, req, v, exp);
    endtask

    task automatic pulse_adv();
        @(negedge clk);
        eng_adv = 1'b1;
        @(negedge clk);
        eng_adv = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk(A_WPTR, 32'h0, "R1 wptr");
        rd_chk(A_RPTR, 32'h0, "R1 rptr");
        rd_chk(A_BASE, 32'h0, "R1 base");
        rd_chk(A_GATE, 32'h0, "R1 gate");
        rd_chk(A_DEPTH, 32'd8192, "R1 size");
        chk(q_count == 0 && q_empty && q_aempty && !q_full && !q_afull, "R1 flags",
            {q_empty, q_full, q_aempty, q_afull}, 32'b1010);

        // R2 base gating
        wr(A_BASE, 32'h1000_0000);
        rd_chk(A_BASE, 32'h0, "R2 locked base");
        wr(A_GATE, 32'h4);
        wr(A_BASE, 32'h1000_0000);
        rd_chk(A_BASE, 32'h1000_0000, "R2 open base");
        chk(eng_desc_addr == 32'h1000_0000, "R11 addr at zero", eng_desc_addr, 32'h1000_0000);
        wr(A_GATE, 32'h0);

        // R4 pointer ownership
        wr(A_RPTR, 32'd96);
        rd_chk(A_RPTR, 32'h0, "R4 locked engine ptr");
        chk(eng_ptr == 0, "R4 eng_ptr", 32'(eng_ptr), 32'h0);
        wr(A_WPTR, 32'd160);
        rd_chk(A_WPTR, 32'd160, "R4 sw ptr");
        chk(q_count == 5, "R6 count after sw write", 32'(q_count), 32'd5);

        // R3 size gating and validation
        wr(A_DEPTH, 32'd64);
        rd_chk(A_DEPTH, 32'd8192, "R3 locked size");
        wr(A_GATE, 32'h2);
        wr(A_DEPTH, 32'd48);
        rd_chk(A_DEPTH, 32'd8192, "R3 non power of two");
        wr(A_DEPTH, 32'd8);
        rd_chk(A_DEPTH, 32'd8192, "R3 count one");
        wr(A_DEPTH, 32'd65);
        rd_chk(A_DEPTH, 32'd8192, "R3 low bits set");
        wr(A_DEPTH, 32'd16384);
        rd_chk(A_DEPTH, 32'd8192, "R3 over maximum");
        wr(A_DEPTH, 32'd64);
        rd_chk(A_DEPTH, 32'd64, "R3 accepted");

        // R5 R6 R7 R8 sweep over every pointer pair for several sizes
        wr(A_GATE, 32'h3);
        for (int d = 2; d <= 16; d = d * 2) begin
            wr(A_DEPTH, 32'(d << 3));
            wr(A_AE, 32'd1);
            wr(A_AF, 32'(d - 2));
            for (int w = 0; w < d; w++) begin
                for (int r = 0; r < d; r++) begin
                    int c;
                    c = ((w - r) % d + d) % d;
                    wr(A_WPTR, 32'(((w + d) << 5) | 5'h1f));
                    wr(A_RPTR, 32'(r << 5));
                    rd_chk(A_WPTR, 32'(w << 5), "R5 masked readback");
                    rd_chk(A_COUNT, 32'(c), "R6 count register");
                    chk(q_count == 10'(c), "R6 count port", 32'(q_count), 32'(c));
                    chk(q_empty == (c == 0) && q_full == (c == d - 1), "R7 flags",
                        {q_empty, q_full}, {(c == 0), (c == d - 1)});
                    chk(q_aempty == (c <= 1) && q_afull == (c >= d - 2), "R8 flags",
                        {q_aempty, q_afull}, {(c <= 1), (c >= d - 2)});
                end
            end
        end

        // R9 engine advance, blocking when empty, wrap
        wr(A_DEPTH, 32'd64);
        wr(A_RPTR, 32'd0);
        wr(A_WPTR, 32'd96);
        wr(A_GATE, 32'h0);
        for (int k = 1; k <= 3; k++) begin
            pulse_adv();
            chk(eng_ptr == 15'(k * 32), "R9 advance", 32'(eng_ptr), 32'(k * 32));
            chk(q_count == 10'(3 - k), "R9 count drop", 32'(q_count), 32'(3 - k));
        end
        pulse_adv();
        chk(eng_ptr == 15'd96 && q_empty, "R9 blocked when empty", 32'(eng_ptr), 32'd96);
        chk(eng_desc_addr == 32'h1000_0060, "R11 addr", eng_desc_addr, 32'h1000_0060);
        wr(A_GATE, 32'h1);
        wr(A_RPTR, 32'd224);
        wr(A_WPTR, 32'd32);
        pulse_adv();
        chk(eng_ptr == 15'd0, "R9 wrap", 32'(eng_ptr), 32'd0);
        chk(q_count == 1, "R9 count after wrap", 32'(q_count), 32'd1);

        // R10 load beats advance in the same cycle
        wr(A_WPTR, 32'd192);
        @(negedge clk);
        reg_addr = A_RPTR; reg_wdata = 32'd160; reg_wr = 1'b1; eng_adv = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; eng_adv = 1'b0;
        chk(eng_ptr == 15'd160, "R10 load wins", 32'(eng_ptr), 32'd160);
        rd(A_RPTR, v);
        chk(v == 32'd160, "R10 readback", v, 32'd160);
        chk(eng_desc_addr == 32'h1000_00a0, "R11 addr after load", eng_desc_addr, 32'h1000_00a0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule